// File: doc/BRIEF.md
# Gated Four-Channel Bin Scaler

This block counts rising edges on four pulse inputs into a sequence of time bins. All four channels count into the currently open bin together, and each has its own counter. A bin stays open for as long as needed. It closes only when a rising edge arrives on the bin-advance strobe. The four totals of the closed bin are then stored as one entry in an internal buffer, and the counters restart at zero.

At arm time the host supplies the total number of strobes expected for a whole acquisition, which is bins per cycle multiplied by cycles per acquisition. The block counts the strobes it accepts and shows that count on a port, so the host can poll for the end of the run. When the count reaches the limit, the block raises a done flag. After that it stops counting and ignores further strobes until it is armed again.

An optional gate can hold counting off between cycles. The host reads the buffer out through a simple one-word read port, one 32-bit channel word at a time, while acquisition is still running.

Top module: `mcs_bin_scaler`

## Requirements
- R1: After reset the strobe count is 0, done and overflow are low, the buffer reports empty and no read data is flagged valid.
- R2: While armed, every rising edge on each of the four channel inputs adds one to that channel's counter for the open bin, and the four channels count independently and at the same time.
- R3: Each accepted strobe rising edge closes the open bin and appends one entry of four words to the buffer, read out in channel order 0, 1, 2, 3. The counters then restart at zero for the next bin.
- R4: The strobe count output goes up by exactly one for each accepted strobe edge.
- R5: When the strobe count reaches the loaded limit, done goes high. Until the next arm, later strobe edges leave the strobe count and buffer unchanged, and channel edges are not counted.
- R6: An arm pulse loads the limit and clears the channel counters, the strobe count, done and overflow. A limit of zero makes done go high straight after the arm, with no strobe accepted.
- R7: When gate enable is high and the gate is low, channel edges are not counted. When gate enable is low, the gate level has no effect.
- R8: If a bin closes while the buffer holds its full depth of entries, overflow is set and stays set until the next arm. The closed bin is dropped and the entries already stored are kept.
- R9: A read request while the buffer is not empty returns the next word on the following cycle with the valid flag high. A read request while the buffer is empty gives no valid word.
- R10: Strobe and channel edges that arrive before the first arm are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | One-cycle pulse: load limit, clear counts and start acquisition |
| limit_i | input | LIMW | Total strobes for one acquisition, sampled on arm |
| gate_en_i | input | 1 | Selects whether the gate is used |
| gate_i | input | 1 | Counting allowed while high (when gate enable is high) |
| chan_i | input | NCH | Asynchronous pulse inputs, one per channel |
| strobe_i | input | 1 | Asynchronous bin-advance strobe |
| rd_en_i | input | 1 | Read one word from the buffer |
| rd_data_o | output | CW | Word read from the buffer |
| rd_valid_o | output | 1 | rd_data_o holds a word this cycle |
| fifo_empty_o | output | 1 | Buffer holds no unread word |
| fifo_level_o | output | $clog2(DEPTH)+1 | Number of bin entries held |
| strobe_cnt_o | output | LIMW | Accepted strobes since the last arm |
| done_o | output | 1 | Limit reached |
| overflow_o | output | 1 | A bin was dropped because the buffer was full |

## Verification
The bench goes after the end of acquisition. A design that keeps taking strobes after the limit would raise the strobe count and leave an extra bin in the buffer, and the final drain would expose it. Gate handling is tested by sending edges while the gate is held closed. A design that ignored the gate would return nonzero words for that channel.

The bench fills the buffer to its depth and then closes one more bin. A wrong design would either overwrite a stored entry, which shows up as an unexpected word during the drain, or fail to raise the sticky overflow flag. Further checks cover strobes sent before any arm, a zero limit, and reads from an empty buffer. These catch designs that start counting early, hang waiting for a strobe that never comes, or flag stale data as valid.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } acq_state_t;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mcs_edge_sync.sv
module mcs_edge_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] rise_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q, s3_q, rise_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        s3_q   <= 1'b0;
        rise_q <= 1'b0;
      end else begin
        s1_q   <= async_i[g];
        s2_q   <= s1_q;
        s3_q   <= s2_q;
        rise_q <= s2_q & ~s3_q;
      end
    end
    assign rise_o[g] = rise_q;
  end
endmodule

// File: rtl/mcs_bin_bank.sv
module mcs_bin_bank #(
  parameter int NCH = 4,
  parameter int CW  = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear_i,
  input  logic            count_en_i,
  input  logic [NCH-1:0]  hit_i,
  input  logic            close_i,
  output logic [NCH*CW-1:0] bin_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_next;
    assign cnt_next = cnt_q + ((count_en_i && hit_i[c]) ? CW'(1) : CW'(0));
    always_ff @(posedge clk) begin
      if (rst || clear_i) begin
        cnt_q <= '0;
      end else if (close_i) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_next;
      end
    end
    // closing snapshot includes an edge that lands in the closing cycle
    assign bin_o[c*CW +: CW] = cnt_next;
  end
endmodule

// File: rtl/mcs_bin_fifo.sv
module mcs_bin_fifo #(
  parameter int NCH   = 4,
  parameter int CW    = 32,
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic [NCH*CW-1:0] push_data_i,
  input  logic              rd_en_i,
  output logic [CW-1:0]     rd_data_o,
  output logic              rd_valid_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [$clog2(DEPTH):0] level_o
);
  localparam int AW = mcs_pkg::idx_width(DEPTH);
  localparam int IW = mcs_pkg::idx_width(NCH);
  localparam int LW = $clog2(DEPTH) + 1;

  logic [NCH*CW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [IW-1:0] word_q, sel_q;
  logic [LW-1:0] count_q;
  logic [NCH*CW-1:0] line_q;
  logic valid_q;
  logic rd_fire, pop, push_ok;

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == LW'(DEPTH));
  assign level_o = count_q;
  assign rd_fire = rd_en_i && !empty_o;
  assign pop     = rd_fire && (word_q == IW'(NCH-1));
  assign push_ok = push_i && !full_o;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (rd_fire) line_q <= mem[rd_ptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      word_q   <= '0;
      sel_q    <= '0;
      count_q  <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= rd_fire;
      if (rd_fire) begin
        sel_q  <= word_q;
        word_q <= pop ? '0 : word_q + IW'(1);
      end
      if (pop) rd_ptr_q <= (rd_ptr_q == AW'(DEPTH-1)) ? '0 : rd_ptr_q + AW'(1);
      if (push_ok) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH-1)) ? '0 : wr_ptr_q + AW'(1);
      case ({push_ok, pop})
        2'b10:   count_q <= count_q + LW'(1);
        2'b01:   count_q <= count_q - LW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  assign rd_data_o  = line_q[sel_q*CW +: CW];
  assign rd_valid_o = valid_q;
endmodule

// File: rtl/mcs_bin_scaler.sv
module mcs_bin_scaler #(
  parameter int NCH   = 4,
  parameter int CW    = 32,
  parameter int LIMW  = 24,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_i,
  input  logic [LIMW-1:0]  limit_i,
  input  logic             gate_en_i,
  input  logic             gate_i,
  input  logic [NCH-1:0]   chan_i,
  input  logic             strobe_i,
  input  logic             rd_en_i,
  output logic [CW-1:0]    rd_data_o,
  output logic             rd_valid_o,
  output logic             fifo_empty_o,
  output logic [$clog2(DEPTH):0] fifo_level_o,
  output logic [LIMW-1:0]  strobe_cnt_o,
  output logic             done_o,
  output logic             overflow_o
);
  import mcs_pkg::*;

  acq_state_t state_q;
  logic [LIMW-1:0] limit_q, scnt_q;
  logic overflow_q;
  logic [NCH-1:0] hit;
  logic strobe_rise, close, count_en, fifo_full;
  logic [NCH*CW-1:0] bin_snap;

  mcs_edge_sync #(.W(NCH)) u_chan_sync (
    .clk(clk), .rst(rst), .async_i(chan_i), .rise_o(hit)
  );

  mcs_edge_sync #(.W(1)) u_strobe_sync (
    .clk(clk), .rst(rst), .async_i(strobe_i), .rise_o(strobe_rise)
  );

  assign close    = (state_q == ST_RUN) && strobe_rise && !arm_i;
  assign count_en = (state_q == ST_RUN) && (!gate_en_i || gate_i);

  mcs_bin_bank #(.NCH(NCH), .CW(CW)) u_bank (
    .clk(clk), .rst(rst), .clear_i(arm_i), .count_en_i(count_en),
    .hit_i(hit), .close_i(close), .bin_o(bin_snap)
  );

  mcs_bin_fifo #(.NCH(NCH), .CW(CW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push_i(close), .push_data_i(bin_snap),
    .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .empty_o(fifo_empty_o), .full_o(fifo_full), .level_o(fifo_level_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      limit_q    <= '0;
      scnt_q     <= '0;
      overflow_q <= 1'b0;
    end else if (arm_i) begin
      limit_q    <= limit_i;
      scnt_q     <= '0;
      overflow_q <= 1'b0;
      state_q    <= (limit_i == '0) ? ST_DONE : ST_RUN;
    end else if (close) begin
      scnt_q <= scnt_q + LIMW'(1);
      if (fifo_full) overflow_q <= 1'b1;
      if (scnt_q + LIMW'(1) == limit_q) state_q <= ST_DONE;
    end
  end

  assign strobe_cnt_o = scnt_q;
  assign done_o       = (state_q == ST_DONE);
  assign overflow_o   = overflow_q;
endmodule

// File: rtl/mcs_bin_scaler_chk.sv
module mcs_bin_scaler_chk #(
  parameter int LIMW = 24
) (
  input logic            clk,
  input logic            rst,
  input logic            arm_i,
  input logic            rd_en_i,
  input logic            fifo_empty_o,
  input logic            rd_valid_o,
  input logic            done_o,
  input logic            overflow_o,
  input logic [LIMW-1:0] strobe_cnt_o,
  input logic [LIMW-1:0] limit_q
);
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (rst)
    (strobe_cnt_o != $past(strobe_cnt_o)) |->
      ((strobe_cnt_o == $past(strobe_cnt_o) + LIMW'(1)) || $past(arm_i)));

  p_done_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    (done_o && !arm_i) |=> $stable(strobe_cnt_o));

  p_cnt_le_limit_r5: assert property (@(posedge clk) disable iff (rst)
    strobe_cnt_o <= limit_q);

  p_arm_clear_r6: assert property (@(posedge clk) disable iff (rst)
    arm_i |=> (strobe_cnt_o == '0) && !overflow_o);

  p_no_overflow_loss_r8: assert property (@(posedge clk) disable iff (rst)
    (overflow_o && !arm_i) |=> overflow_o);

  p_empty_read_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && fifo_empty_o) |=> !rd_valid_o);
endmodule

bind mcs_bin_scaler mcs_bin_scaler_chk #(.LIMW(LIMW)) u_chk (
  .clk(clk), .rst(rst), .arm_i(arm_i), .rd_en_i(rd_en_i),
  .fifo_empty_o(fifo_empty_o), .rd_valid_o(rd_valid_o), .done_o(done_o),
  .overflow_o(overflow_o), .strobe_cnt_o(strobe_cnt_o), .limit_q(limit_q)
);

// File: tb/mcs_bin_scaler_tb_top.sv
module mcs_bin_scaler_tb_top;
  localparam int NCH = 4, CW = 32, LIMW = 24, DEPTH = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic arm_i = 0, gate_en_i = 0, gate_i = 0, strobe_i = 0, rd_en_i = 0;
  logic [LIMW-1:0] limit_i = '0;
  logic [NCH-1:0] chan_i = '0;
  logic [CW-1:0] rd_data_o;
  logic rd_valid_o, fifo_empty_o, done_o, overflow_o;
  logic [$clog2(DEPTH):0] fifo_level_o;
  logic [LIMW-1:0] strobe_cnt_o;

  int checks = 0, errors = 0;
  logic [CW-1:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  mcs_bin_scaler #(.NCH(NCH), .CW(CW), .LIMW(LIMW), .DEPTH(DEPTH)) dut_i (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected words as the read port produces them
  always @(negedge clk) begin
    if (!rst && rd_valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected word", rd_data_o, -1);
      end else begin
        logic [CW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data_o == e, t, rd_data_o, e);
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_bin(input int c0, input int c1, input int c2, input int c3, input string t);
    exp_q.push_back(c0); tag_q.push_back({t, " ch0"});
    exp_q.push_back(c1); tag_q.push_back({t, " ch1"});
    exp_q.push_back(c2); tag_q.push_back({t, " ch2"});
    exp_q.push_back(c3); tag_q.push_back({t, " ch3"});
  endtask

  task automatic pulse_ch(input int ch, input int n);
    for (int i = 0; i < n; i++) begin
      chan_i[ch] = 1'b1; cycles(2);
      chan_i[ch] = 1'b0; cycles(2);
    end
    cycles(4);
  endtask

  task automatic strobe();
    strobe_i = 1'b1; cycles(2);
    strobe_i = 1'b0; cycles(6);
  endtask

  task automatic arm(input int lim);
    limit_i = LIMW'(lim);
    arm_i = 1'b1; cycles(1);
    arm_i = 1'b0; cycles(1);
  endtask

  task automatic drain();
    while (!fifo_empty_o) begin
      rd_en_i = 1'b1; cycles(1);
      rd_en_i = 1'b0; cycles(1);
    end
    cycles(3);
  endtask

  initial begin
    cycles(100000);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cycles(3);
    rst = 1'b0;
    cycles(1);
    // R1 reset state
    check(strobe_cnt_o == 0, "R1 strobe count", strobe_cnt_o, 0);
    check(!done_o && !overflow_o, "R1 flags", {done_o, overflow_o}, 0);
    check(fifo_empty_o && !rd_valid_o, "R1 empty", fifo_empty_o, 1);

    // R10 activity before arm is ignored
    pulse_ch(0, 2);
    strobe();
    check(strobe_cnt_o == 0, "R10 strobe count", strobe_cnt_o, 0);
    check(fifo_empty_o, "R10 buffer empty", fifo_empty_o, 1);

    // R2/R3/R4 three bins, limit 3
    arm(3);
    pulse_ch(0, 3); pulse_ch(1, 1); pulse_ch(3, 2);
    expect_bin(3, 1, 0, 2, "R2 R3 bin0");
    strobe();
    check(strobe_cnt_o == 1, "R4 count after 1", strobe_cnt_o, 1);
    check(fifo_level_o == 1, "R3 one entry", fifo_level_o, 1);

    // R7 gate held low blocks counting on ch0, then open for ch1
    gate_en_i = 1'b1; gate_i = 1'b0;
    pulse_ch(0, 2);
    gate_i = 1'b1;
    pulse_ch(1, 4);
    gate_en_i = 1'b0; gate_i = 1'b0;
    pulse_ch(2, 1);
    expect_bin(0, 4, 1, 0, "R7 gated bin");
    strobe();
    check(strobe_cnt_o == 2, "R4 count after 2", strobe_cnt_o, 2);

    pulse_ch(3, 5);
    expect_bin(0, 0, 0, 5, "R3 bin2");
    strobe();
    check(done_o, "R5 done at limit", done_o, 1);
    check(strobe_cnt_o == 3, "R5 count at limit", strobe_cnt_o, 3);

    // R5 strobes and edges after done are ignored
    pulse_ch(0, 2);
    strobe(); strobe();
    check(strobe_cnt_o == 3, "R5 count frozen", strobe_cnt_o, 3);
    check(fifo_level_o == 3, "R5 no extra bin", fifo_level_o, 3);
    drain();
    check(exp_q.size() == 0, "R3 all words read", exp_q.size(), 0);

    // R9 read while empty
    rd_en_i = 1'b1; cycles(1); rd_en_i = 1'b0;
    check(!rd_valid_o, "R9 empty read", rd_valid_o, 0);
    cycles(2);

    // R6 zero limit
    arm(0);
    check(done_o, "R6 zero limit done", done_o, 1);
    strobe();
    check(strobe_cnt_o == 0 && fifo_empty_o, "R6 zero limit no strobe", strobe_cnt_o, 0);

    // R8 overflow
    arm(20);
    check(!done_o && strobe_cnt_o == 0, "R6 rearm clears", strobe_cnt_o, 0);
    for (int b = 0; b < DEPTH; b++) begin
      expect_bin(0, 0, 0, 0, "R8 kept bin");
      strobe();
    end
    check(!overflow_o, "R8 no overflow when just full", overflow_o, 0);
    pulse_ch(2, 1);
    strobe();
    check(overflow_o, "R8 overflow set", overflow_o, 1);
    check(fifo_level_o == DEPTH, "R8 level held", fifo_level_o, DEPTH);
    drain();
    check(overflow_o, "R8 overflow sticky", overflow_o, 1);
    check(exp_q.size() == 0, "R8 stored bins intact", exp_q.size(), 0);
    arm(2);
    check(!overflow_o, "R6 arm clears overflow", overflow_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule